// File: doc/BRIEF.md
# Processor Startup IPI Sequencer

This block sits beside the interrupt-command register of a multiprocessor system. Each accepted 64-bit command word is decoded into a set of target processors. Fixed and non-maskable commands are then delivered to those targets one at a time, and the INIT and startup messages drive each processor through its own boot sequence.

Every processor slot holds a three-state boot machine: held in INIT, waiting for a startup message, or running. Only processor 0 can move another processor forward. A startup message that finds its target waiting sends out a one-cycle spin-up request with the target index and a 4 KiB-aligned start address. Any command the block does not handle raises a one-cycle `unhandled` pulse, so that a slower agent can deal with it.

Commands are offered on `cmd_valid`. One is taken on a rising edge when `cmd_ready` is high. Every registered effect of a command shows up in the cycle after that edge.

Top module: `ipi_boot_seq`

## Requirements
- R1: After reset, processor 0 reports running (state code 2) and every other processor reports init (state code 0). `dlv_valid`, `unhandled`, `spin_valid` and `dest_mask` are all zero, and `cmd_ready` is high.
- R2: The destination index is command bits 63:56 when `xmode_en` is low, and bits 63:32 when it is high.
- R3: For fixed delivery (mode bits 10:8 = 000) or NMI delivery (100), the shorthand in bits 19:18 selects the targets. Code 00 selects the single processor named by the destination index, or none if that index is not below NUM_CPU. Code 01 selects the sender. Code 10 selects every running processor. Code 11 selects every running processor except the sender. The selection appears on `dest_mask` in the cycle after acceptance and stays there until the next fixed or NMI command.
- R4: The selected targets are delivered one per cycle in ascending index order, starting in the cycle after acceptance. `cmd_ready` is low while any delivery is outstanding, and a command held on `cmd_valid` during that time is not taken.
- R5: Each delivery carries the command's vector (bits 7:0). `dlv_nmi` is high exactly for NMI-mode commands.
- R6: An INIT command (mode 101) whose level bit 14 is 0 changes no boot state and raises no `unhandled`.
- R7: An INIT command with level bit 14 set, sent by processor 0 to a destination index that is nonzero and below NUM_CPU, moves a target in init to waiting (state code 1). A target in any other state is left as it is.
- R8: A startup command (mode 110) from processor 0 to a nonzero destination below NUM_CPU moves a waiting target to running, which makes it active. In the next cycle it pulses `spin_valid` with `spin_cpu` set to the target and `spin_addr` set to the vector shifted left by 12 bits.
- R9: A startup command whose target is not waiting changes no state and raises neither `spin_valid` nor `unhandled`.
- R10: `unhandled` pulses for one cycle after any accepted command that is not covered by R3 to R9. This includes the other modes, and an asserted INIT or a startup from a processor other than 0 or to destination 0 or a destination at or above NUM_CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | High when a command can be taken this edge |
| cmd_word | input | 64 | Interrupt command word |
| cmd_sender | input | IDX_W | Index of the issuing processor |
| xmode_en | input | 1 | Selects 32-bit destination field |
| dest_mask | output | NUM_CPU | Targets of the last fixed/NMI command |
| dlv_valid | output | 1 | One delivery this cycle |
| dlv_target | output | IDX_W | Processor receiving the delivery |
| dlv_nmi | output | 1 | Delivery is non-maskable |
| dlv_vector | output | 8 | Delivered vector |
| spin_valid | output | 1 | Spin-up request pulse |
| spin_cpu | output | IDX_W | Processor to start |
| spin_addr | output | 20 | Start address |
| unhandled | output | 1 | Command not handled here |
| boot_state | output | 2*NUM_CPU | Per-processor boot state, 2 bits each |

## Verification
The hardest case to reach is a broadcast that expands to a sparse set of running processors. Before the delivery order and the excluding shorthand can be tested, some processors other than 0 must already have been brought to running through the full INIT-then-startup sequence. The stimulus therefore first boots processor 1 in legacy mode and processor 3 in extended mode, leaving processor 2 held in init. It then issues including and excluding broadcasts from different senders, holding `cmd_valid` through each drain so that the stall is exercised as well.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   typedef enum logic [1:0] {
      BOOT_HELD  = 2'd0,
      BOOT_WAIT  = 2'd1,
      BOOT_RUN   = 2'd2
   } boot_e;

   localparam logic [2:0] MODE_FIXED = 3'b000;
   localparam logic [2:0] MODE_NMI   = 3'b100;
   localparam logic [2:0] MODE_INIT  = 3'b101;
   localparam logic [2:0] MODE_START = 3'b110;

   typedef enum logic [1:0] {
      SH_FIELD   = 2'd0,
      SH_SELF    = 2'd1,
      SH_ALL     = 2'd2,
      SH_OTHERS  = 2'd3
   } shorthand_e;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
   import ipi_pkg::*;
#(
   parameter int NUM_CPU = 4,
   localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic [63:0]        cmd,
   input  logic [IDX_W-1:0]   sender,
   input  logic               xmode,
   input  logic [NUM_CPU-1:0] running,
   output logic [31:0]        dest_idx,
   output logic               dest_ok,
   output logic               from_bsp,
   output logic               is_dlv,
   output logic               is_nmi,
   output logic               is_init,
   output logic               is_start,
   output logic               level_hi,
   output logic [NUM_CPU-1:0] tgt_mask
);
   logic [2:0]         mode;
   shorthand_e         sh;
   logic [NUM_CPU-1:0] field_hot;
   logic [NUM_CPU-1:0] self_hot;

   assign mode     = cmd[10:8];
   assign sh       = shorthand_e'(cmd[19:18]);
   assign level_hi = cmd[14];
   assign dest_idx = xmode ? cmd[63:32] : {24'd0, cmd[63:56]};
   assign dest_ok  = (dest_idx != 32'd0) && (dest_idx < 32'(NUM_CPU));
   assign from_bsp = (sender == '0);
   assign is_nmi   = (mode == MODE_NMI);
   assign is_dlv   = (mode == MODE_FIXED) || is_nmi;
   assign is_init  = (mode == MODE_INIT);
   assign is_start = (mode == MODE_START);

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_hot
      assign field_hot[g] = (dest_idx == 32'(g));
      assign self_hot[g]  = (32'(sender) == 32'(g));
   end

   always_comb begin
      unique case (sh)
         SH_FIELD:  tgt_mask = field_hot;
         SH_SELF:   tgt_mask = self_hot;
         SH_ALL:    tgt_mask = running;
         SH_OTHERS: tgt_mask = running & ~self_hot;
         default:   tgt_mask = '0;
      endcase
   end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
   parameter int N      = 4,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     hot
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end

   assign hot = any ? ({{(N-1){1'b0}}, 1'b1} << idx) : '0;
endmodule

// File: rtl/cpu_boot_slot.sv
module cpu_boot_slot
   import ipi_pkg::*;
#(
   parameter bit IS_BSP = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  go_wait,
   input  logic  go_run,
   output boot_e state
);
   localparam boot_e RST_STATE = IS_BSP ? BOOT_RUN : BOOT_HELD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RST_STATE;
      end else if (go_wait && state == BOOT_HELD) begin
         state <= BOOT_WAIT;
      end else if (go_run && state == BOOT_WAIT) begin
         state <= BOOT_RUN;
      end
   end
endmodule

// File: rtl/ipi_boot_seq.sv
module ipi_boot_seq
   import ipi_pkg::*;
#(
   parameter int NUM_CPU = 4,
   localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic [63:0]            cmd_word,
   input  logic [IDX_W-1:0]       cmd_sender,
   input  logic                   xmode_en,
   output logic [NUM_CPU-1:0]     dest_mask,
   output logic                   dlv_valid,
   output logic [IDX_W-1:0]       dlv_target,
   output logic                   dlv_nmi,
   output logic [7:0]             dlv_vector,
   output logic                   spin_valid,
   output logic [IDX_W-1:0]       spin_cpu,
   output logic [19:0]            spin_addr,
   output logic                   unhandled,
   output logic [2*NUM_CPU-1:0]   boot_state
);
   if (NUM_CPU < 2 || NUM_CPU > 256) begin : g_bad_cfg
      $error("ipi_boot_seq: NUM_CPU must lie in 2..256");
   end

   logic [31:0]        dest_idx;
   logic               dest_ok, from_bsp, is_dlv, is_nmi, is_init, is_start, level_hi;
   logic [NUM_CPU-1:0] tgt_mask, running, waiting, go_wait, go_run;
   logic [NUM_CPU-1:0] pend_q, pick_hot;
   logic               pick_any, accept, init_ok, start_ok;
   logic               nmi_q, unh_q, spin_q;
   logic [7:0]         vec_q;
   logic [IDX_W-1:0]   spin_cpu_q;
   logic [19:0]        spin_addr_q;

   ipi_decode #(.NUM_CPU(NUM_CPU)) u_dec (
      .cmd      (cmd_word),
      .sender   (cmd_sender),
      .xmode    (xmode_en),
      .running  (running),
      .dest_idx (dest_idx),
      .dest_ok  (dest_ok),
      .from_bsp (from_bsp),
      .is_dlv   (is_dlv),
      .is_nmi   (is_nmi),
      .is_init  (is_init),
      .is_start (is_start),
      .level_hi (level_hi),
      .tgt_mask (tgt_mask)
   );

   lowest_pick #(.N(NUM_CPU)) u_pick (
      .req (pend_q),
      .any (pick_any),
      .idx (dlv_target),
      .hot (pick_hot)
   );

   assign cmd_ready = ~pick_any;
   assign accept    = cmd_valid & cmd_ready;
   assign init_ok   = is_init & level_hi & from_bsp & dest_ok;
   assign start_ok  = is_start & from_bsp & dest_ok;

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
      boot_e st;
      assign go_wait[g] = accept & init_ok & (dest_idx == 32'(g));
      assign go_run[g]  = accept & start_ok & (dest_idx == 32'(g));

      cpu_boot_slot #(.IS_BSP(g == 0)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .go_wait (go_wait[g]),
         .go_run  (go_run[g]),
         .state   (st)
      );

      assign running[g]          = (st == BOOT_RUN);
      assign waiting[g]          = (st == BOOT_WAIT);
      assign boot_state[2*g +: 2] = st;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= '0;
         dest_mask   <= '0;
         nmi_q       <= 1'b0;
         vec_q       <= '0;
         unh_q       <= 1'b0;
         spin_q      <= 1'b0;
         spin_cpu_q  <= '0;
         spin_addr_q <= '0;
      end else begin
         unh_q  <= accept & ~(is_dlv | (is_init & ~level_hi) | init_ok | start_ok);
         spin_q <= |(go_run & waiting);
         if (accept && is_dlv) begin
            pend_q    <= tgt_mask;
            dest_mask <= tgt_mask;
            nmi_q     <= is_nmi;
            vec_q     <= cmd_word[7:0];
         end else begin
            pend_q <= pend_q & ~pick_hot;
         end
         if (accept && start_ok) begin
            spin_cpu_q  <= dest_idx[IDX_W-1:0];
            spin_addr_q <= {cmd_word[7:0], 12'd0};
         end
      end
   end

   assign dlv_valid  = pick_any;
   assign dlv_nmi    = nmi_q;
   assign dlv_vector = vec_q;
   assign unhandled  = unh_q;
   assign spin_valid = spin_q;
   assign spin_cpu   = spin_cpu_q;
   assign spin_addr  = spin_addr_q;
endmodule

// File: rtl/ipi_boot_seq_chk.sv
module ipi_boot_seq_chk #(
   parameter int NUM_CPU = 4,
   localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_valid,
   input logic                 cmd_ready,
   input logic [NUM_CPU-1:0]   dest_mask,
   input logic                 dlv_valid,
   input logic [IDX_W-1:0]     dlv_target,
   input logic                 spin_valid,
   input logic [IDX_W-1:0]     spin_cpu,
   input logic                 unhandled,
   input logic [2*NUM_CPU-1:0] boot_state
);
   AST_BSP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      boot_state[1:0] == 2'd2); // R1

   AST_DLV_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> dest_mask[dlv_target]); // R4

   AST_DLV_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && $past(dlv_valid)) |-> (dlv_target > $past(dlv_target))); // R4

   AST_SPIN_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      spin_valid |-> ($past(cmd_valid) && $past(cmd_ready))); // R8

   AST_SPIN_NOT_BSP: assert property (@(posedge clk) disable iff (!rst_n)
      spin_valid |-> (spin_cpu != '0)); // R8

   AST_UNH_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      unhandled |-> ($past(cmd_valid) && $past(cmd_ready))); // R10

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_fwd
      AST_STATE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
         (boot_state[2*g +: 2] != $past(boot_state[2*g +: 2])) |->
         (boot_state[2*g +: 2] == $past(boot_state[2*g +: 2]) + 2'd1)); // R7
   end
endmodule

bind ipi_boot_seq ipi_boot_seq_chk #(.NUM_CPU(NUM_CPU)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .dest_mask  (dest_mask),
   .dlv_valid  (dlv_valid),
   .dlv_target (dlv_target),
   .spin_valid (spin_valid),
   .spin_cpu   (spin_cpu),
   .unhandled  (unhandled),
   .boot_state (boot_state)
);

// File: tb/ipi_boot_seq_tb.sv
`timescale 1ns/1ps
module ipi_boot_seq_tb;
   localparam int N  = 4;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [63:0]   cmd_word = '0;
   logic [IW-1:0] cmd_sender = '0;
   logic          xmode_en = 1'b0;
   logic          cmd_ready, dlv_valid, dlv_nmi, spin_valid, unhandled;
   logic [N-1:0]  dest_mask;
   logic [IW-1:0] dlv_target, spin_cpu;
   logic [7:0]    dlv_vector;
   logic [19:0]   spin_addr;
   logic [2*N-1:0] boot_state;

   always #2 clk = ~clk;

   ipi_boot_seq #(.NUM_CPU(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_word(cmd_word), .cmd_sender(cmd_sender), .xmode_en(xmode_en),
      .dest_mask(dest_mask), .dlv_valid(dlv_valid), .dlv_target(dlv_target),
      .dlv_nmi(dlv_nmi), .dlv_vector(dlv_vector), .spin_valid(spin_valid),
      .spin_cpu(spin_cpu), .spin_addr(spin_addr), .unhandled(unhandled),
      .boot_state(boot_state)
   );

   // behavioural reference model
   int      ms [N];
   int      mq [$];
   bit      e_nmi, e_unh, e_spin, m_acc, m_rdy, cmp_en, done;
   int      e_vec, e_spin_cpu, e_spin_addr;
   logic [N-1:0] e_mask;
   int      n_vec, n_bad;

   task automatic model_reset();
      for (int i = 0; i < N; i++) ms[i] = (i == 0) ? 2 : 0;
      mq.delete();
      e_nmi = 0; e_unh = 0; e_spin = 0; e_vec = 0; e_mask = '0;
      e_spin_cpu = 0; e_spin_addr = 0;
   endtask

   task automatic model_cmd();
      int mode, sh, snd;
      longint unsigned dst;
      bit ok;
      mode = int'(cmd_word[10:8]);
      sh   = int'(cmd_word[19:18]);
      snd  = int'(cmd_sender);
      dst  = xmode_en ? longint'(cmd_word[63:32]) : longint'(cmd_word[63:56]);
      ok   = (snd == 0) && (dst != 0) && (dst < N);
      if (mode == 0 || mode == 4) begin
         for (int i = 0; i < N; i++) begin
            bit hit;
            case (sh)
               0: hit = (dst == i);
               1: hit = (snd == i);
               2: hit = (ms[i] == 2);
               default: hit = (ms[i] == 2) && (snd != i);
            endcase
            e_mask[i] = hit;
            if (hit) mq.push_back(i);
         end
         e_nmi = (mode == 4);
         e_vec = int'(cmd_word[7:0]);
      end else if (mode == 5) begin
         if (cmd_word[14]) begin
            if (ok) begin
               if (ms[dst] == 0) ms[dst] = 1;
            end else e_unh = 1;
         end
      end else if (mode == 6) begin
         if (ok) begin
            if (ms[dst] == 1) begin
               ms[dst] = 2;
               e_spin = 1;
               e_spin_cpu = int'(dst);
               e_spin_addr = int'(cmd_word[7:0]) << 12;
            end
         end else e_unh = 1;
      end else e_unh = 1;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         m_rdy = (mq.size() == 0);
         e_unh = 0;
         e_spin = 0;
         if (!m_rdy) void'(mq.pop_front());
         if (cmd_valid && m_rdy) begin
            m_acc = 1;
            model_cmd();
         end
      end
   end

   task automatic chk(string req, string what, longint act, longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // compared on every clock, away from the active edge
   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R4", "cmd_ready", cmd_ready, mq.size() == 0);
         chk("R4", "dlv_valid", dlv_valid, mq.size() != 0);
         if (mq.size() != 0) begin
            chk("R4", "dlv_target", dlv_target, mq[0]);
            chk("R5", "dlv_nmi", dlv_nmi, e_nmi);
            chk("R5", "dlv_vector", dlv_vector, e_vec);
         end
         chk("R3", "dest_mask", dest_mask, e_mask);
         chk("R10", "unhandled", unhandled, e_unh);
         chk("R8", "spin_valid", spin_valid, e_spin);
         if (e_spin) begin
            chk("R8", "spin_cpu", spin_cpu, e_spin_cpu);
            chk("R8", "spin_addr", spin_addr, e_spin_addr);
         end
         for (int i = 0; i < N; i++)
            chk("R7", $sformatf("boot_state[%0d]", i), boot_state[2*i +: 2], ms[i]);
      end
   end

   function automatic logic [63:0] mk(int mode, int sh, int lvl, int vec,
                                      longint unsigned dst, bit ext);
      logic [63:0] w;
      w = '0;
      w[7:0]   = vec[7:0];
      w[10:8]  = mode[2:0];
      w[14]    = lvl[0];
      w[19:18] = sh[1:0];
      if (ext) w[63:32] = dst[31:0];
      else     w[63:56] = dst[7:0];
      return w;
   endfunction

   task automatic send(logic [63:0] w, int snd, bit ext);
      @(negedge clk);
      cmd_word   = w;
      cmd_sender = IW'(snd);
      xmode_en   = ext;
      cmd_valid  = 1'b1;
      m_acc      = 0;
      do @(negedge clk); while (!m_acc);
      cmd_valid  = 1'b0;
   endtask

   task automatic drain();
      while (mq.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_en = 1;
      // R1: reset state
      chk("R1", "bsp state", boot_state[1:0], 2);
      chk("R1", "ap states", boot_state[7:2], 0);
      chk("R1", "ready", cmd_ready, 1);

      send(mk(0, 0, 0, 8'h41, 2, 0), 0, 0);            // fixed to cpu2 by field
      drain();
      send(mk(0, 2, 0, 8'h52, 0, 0), 0, 0);            // broadcast, only cpu0 running
      drain();
      send(mk(5, 0, 1, 0, 1, 0), 0, 0);                // INIT cpu1
      send(mk(5, 0, 0, 0, 2, 0), 0, 0);                // INIT deassert cpu2
      chk("R6", "cpu2 after deassert", boot_state[5:4], 0);
      chk("R6", "no unhandled", unhandled, 0);
      send(mk(5, 0, 1, 0, 3, 0), 1, 0);                // INIT from non-bsp
      chk("R10", "init from cpu1", unhandled, 1);
      send(mk(6, 0, 0, 8'h9A, 2, 0), 0, 0);            // startup to held cpu2
      chk("R9", "no spin", spin_valid, 0);
      chk("R9", "no unhandled", unhandled, 0);
      send(mk(6, 0, 0, 8'h9A, 1, 0), 0, 0);            // startup cpu1
      chk("R8", "spin addr", spin_addr, 20'h9A000);
      send(mk(5, 0, 1, 0, 3, 1), 0, 1);                // INIT cpu3 extended dest
      send(mk(6, 0, 0, 8'h07, 3, 1), 0, 1);            // startup cpu3 extended dest
      chk("R2", "cpu3 running via 63:32", boot_state[7:6], 2);
      send(mk(6, 0, 0, 8'h07, 1, 0), 0, 0);            // startup to running cpu1
      chk("R9", "no spin when running", spin_valid, 0);
      send(mk(4, 2, 0, 8'h02, 0, 0), 1, 0);            // NMI all incl, held through drain
      send(mk(0, 3, 0, 8'hE0, 0, 0), 3, 0);            // fixed all excl from cpu3
      send(mk(0, 1, 0, 8'h33, 0, 0), 2, 0);            // self from cpu2
      drain();
      send(mk(0, 0, 0, 8'h11, 5, 1), 0, 1);            // field out of range
      chk("R3", "empty mask", dest_mask, 0);
      send(mk(5, 0, 1, 0, 7, 1), 0, 1);                // INIT to out-of-range
      chk("R10", "init out of range", unhandled, 1);
      send(mk(3, 0, 0, 0, 1, 0), 0, 0);                // reserved mode
      chk("R10", "reserved mode", unhandled, 1);
      send(mk(6, 0, 0, 8'h10, 0, 0), 0, 0);            // startup to cpu0
      chk("R10", "startup to bsp", unhandled, 1);
      send(mk(0, 0, 0, 8'h21, 1, 0), 0, 0);            // legacy dest 1, ext bits zero
      drain();
      repeat (3) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R4 watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end
endmodule